// File: doc/BRIEF.md
# UART Host Register Bank

This block is the byte-wide register file that a host processor sees for a classic PC-style serial port. A 3-bit offset with separate read and write strobes selects one of eight byte locations. Behind them sit a 16-bit baud divisor, an interrupt enable byte, an interrupt identification value, line control, modem control, line status, modem status and a scratch byte. The bank drives one level interrupt toward the host.

On the serial side, received bytes and break events arrive through a one-cycle push interface. Every byte the host writes to the data location leaves on a one-cycle transmit pulse, with no backpressure. The divisor, line control and modem control values are brought out as plain outputs for the serial shifter and modem pins, which live outside this block. Everything is synchronous to a single clock. Reads return data combinationally in the strobe cycle, and their side effects take hold at the closing clock edge.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60, identification (offset 2) reads 0x01, modem status (offset 6) reads 0xB0, and `irq`, `tx_valid` and `divisor` are all zero.
- R2: While line control bit 7 is set, offsets 0 and 1 read and write the low and high bytes of the divisor. A write to offset 0 then sends no transmit pulse, and the interrupt enable byte is left unchanged.
- R3: The interrupt enable byte (offset 1) keeps only bits 3:0, and modem control (offset 4) keeps only bits 4:0. Writes to offsets 2, 5 and 6 have no effect. Offset 7 reads back the last byte written to it.
- R4: Identification reads 0x04 when data-ready (line status bit 0) and receive-interrupt enable (enable bit 0) are both set. Otherwise it reads 0x02 when the transmit-pending flag and transmit-interrupt enable (enable bit 1) are both set. Otherwise it reads 0x01. `irq` is high exactly when identification is not 0x01, and it follows a strobe by one clock.
- R5: A read of offset 2 that returns 0x02 clears transmit-pending, so the next identification read returns 0x01 and `irq` falls.
- R6: Writing the interrupt enable byte while line status bit 5 is set raises transmit-pending.
- R7: A data write (offset 0, line control bit 7 clear) makes `tx_valid` high for exactly one cycle, starting the cycle after the strobe, with the byte on `tx_data`. It also sets line status bits 5 and 6 and raises transmit-pending.
- R8: A data read (offset 0, line control bit 7 clear) returns the receive byte and clears line status bits 0 and 4.
- R9: A pushed byte is taken only while line status bit 0 is clear. It then sets that bit. A byte pushed while bit 0 is set is dropped, and the held byte is kept.
- R10: A break push loads 0x00 into the receive byte and sets line status bits 4 and 0.
- R11: With modem control bit 4 set, a modem status read returns modem control bit 3 on bit 7, bit 2 on bit 6, bit 0 on bit 5 and bit 1 on bit 4, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; triggers read side effects |
| rd_data | output | 8 | Byte at `addr` |
| rx_valid | input | 1 | Received byte push |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break event push |
| tx_valid | output | 1 | One-cycle transmit pulse |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control byte |
| modem_ctrl | output | 8 | Modem control byte |

## Verification
The hidden transmit-pending flag cannot be read directly. A wrong value shows up in the next identification read as 0x02 instead of 0x01 (or the reverse), and in `irq` one clock after the strobe that should have changed it. A line status bit that is stuck or wrongly cleared shows on the next offset 5 read. It also shows through receive acceptance: a dropped or overwritten byte appears on the following data read. Divisor-latch decoding errors appear as a stray transmit pulse in the next cycle or as a corrupted enable byte.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ID   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MCTL = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSTA = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSTA = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

    // bit positions
    localparam int LC_DIVSEL  = 7;
    localparam int LS_READY   = 0;
    localparam int LS_BREAK   = 4;
    localparam int LS_HOLDEMP = 5;
    localparam int LS_TXEMP   = 6;
    localparam int IE_RX      = 0;
    localparam int IE_TX      = 1;
    localparam int MC_LOOP    = 4;

    // identification codes
    localparam logic [BYTE_W-1:0] ID_NONE = 8'h01;
    localparam logic [BYTE_W-1:0] ID_TX   = 8'h02;
    localparam logic [BYTE_W-1:0] ID_RX   = 8'h04;

    localparam logic [BYTE_W-1:0] LS_RESET = 8'h60;

endpackage

// File: rtl/uart_rb_intid.sv
module uart_rb_intid
    import uart_rb_pkg::*;
(
    input  logic              ready,
    input  logic              rx_en,
    input  logic              tx_pend,
    input  logic              tx_en,
    output logic [BYTE_W-1:0] id_code
);
    always_comb begin
        if (ready && rx_en) begin
            id_code = ID_RX;
        end else if (tx_pend && tx_en) begin
            id_code = ID_TX;
        end else begin
            id_code = ID_NONE;
        end
    end
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
    import uart_rb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] ien,
    input  logic [BYTE_W-1:0] id_code,
    input  logic [BYTE_W-1:0] lctl,
    input  logic [BYTE_W-1:0] mctl,
    input  logic [BYTE_W-1:0] lsta,
    input  logic [BYTE_W-1:0] msta,
    input  logic [BYTE_W-1:0] scr,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam int DIV_HI_W = DIV_W - BYTE_W;

    logic              divsel;
    logic [BYTE_W-1:0] loop_sta;
    logic [BYTE_W-1:0] div_hi;

    assign divsel = lctl[LC_DIVSEL];
    assign div_hi = {{(2*BYTE_W-DIV_W){1'b0}}, div_val[DIV_W-1 -: DIV_HI_W]};

    // modem outputs folded back onto status inputs
    always_comb begin
        loop_sta    = '0;
        loop_sta[7] = mctl[3];
        loop_sta[6] = mctl[2];
        loop_sta[5] = mctl[0];
        loop_sta[4] = mctl[1];
    end

    always_comb begin
        unique case (addr)
            OFS_DATA: rd_byte = divsel ? div_val[BYTE_W-1:0] : rx_byte;
            OFS_IEN:  rd_byte = divsel ? div_hi : ien;
            OFS_ID:   rd_byte = id_code;
            OFS_LCTL: rd_byte = lctl;
            OFS_MCTL: rd_byte = mctl;
            OFS_LSTA: rd_byte = lsta;
            OFS_MSTA: rd_byte = mctl[MC_LOOP] ? loop_sta : msta;
            default:  rd_byte = scr;
        endcase
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int               DIV_W     = 16,
    parameter int               IEN_KEEP  = 4,
    parameter int               MCTL_KEEP = 5,
    parameter logic [7:0]       MSTA_INIT = 8'hB0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_break,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq,
    output logic [DIV_W-1:0]  divisor,
    output logic [7:0]        line_ctrl,
    output logic [7:0]        modem_ctrl
);
    localparam int DIV_HI_W = DIV_W - BYTE_W;
    localparam logic [BYTE_W-1:0] IEN_MASK  = BYTE_W'((1 << IEN_KEEP) - 1);
    localparam logic [BYTE_W-1:0] MCTL_MASK = BYTE_W'((1 << MCTL_KEEP) - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [BYTE_W-1:0] rbuf;
        logic [BYTE_W-1:0] ien;
        logic [BYTE_W-1:0] lctl;
        logic [BYTE_W-1:0] mctl;
        logic [BYTE_W-1:0] lsta;
        logic [BYTE_W-1:0] msta;
        logic [BYTE_W-1:0] scr;
        logic              tx_pend;
        logic              irq;
        logic              txv;
        logic [BYTE_W-1:0] txb;
    } bank_t;

    bank_t st_q, st_d;
    logic [BYTE_W-1:0] id_cur, id_nxt;
    logic divsel;

    assign divsel = st_q.lctl[LC_DIVSEL];

    uart_rb_intid u_id_cur (
        .ready   (st_q.lsta[LS_READY]),
        .rx_en   (st_q.ien[IE_RX]),
        .tx_pend (st_q.tx_pend),
        .tx_en   (st_q.ien[IE_TX]),
        .id_code (id_cur)
    );

    uart_rb_intid u_id_nxt (
        .ready   (st_d.lsta[LS_READY]),
        .rx_en   (st_d.ien[IE_RX]),
        .tx_pend (st_d.tx_pend),
        .tx_en   (st_d.ien[IE_TX]),
        .id_code (id_nxt)
    );

    uart_rb_rdmux #(.DIV_W(DIV_W)) u_rdmux (
        .addr    (addr),
        .div_val (st_q.div),
        .rx_byte (st_q.rbuf),
        .ien     (st_q.ien),
        .id_code (id_cur),
        .lctl    (st_q.lctl),
        .mctl    (st_q.mctl),
        .lsta    (st_q.lsta),
        .msta    (st_q.msta),
        .scr     (st_q.scr),
        .rd_byte (rd_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.txv = 1'b0;

        // host writes
        if (wr_en) begin
            unique case (addr)
                OFS_DATA: begin
                    if (divsel) begin
                        st_d.div[BYTE_W-1:0] = wr_data;
                    end else begin
                        st_d.txv               = 1'b1;
                        st_d.txb               = wr_data;
                        st_d.lsta[LS_HOLDEMP]  = 1'b1;
                        st_d.lsta[LS_TXEMP]    = 1'b1;
                        st_d.tx_pend           = 1'b1;
                    end
                end
                OFS_IEN: begin
                    if (divsel) begin
                        st_d.div[DIV_W-1 -: DIV_HI_W] = wr_data[DIV_HI_W-1:0];
                    end else begin
                        st_d.ien = wr_data & IEN_MASK;
                        if (st_q.lsta[LS_HOLDEMP]) begin
                            st_d.tx_pend = 1'b1;
                        end
                    end
                end
                OFS_LCTL: st_d.lctl = wr_data;
                OFS_MCTL: st_d.mctl = wr_data & MCTL_MASK;
                OFS_SCR:  st_d.scr  = wr_data;
                default:  ;
            endcase
        end

        // host read side effects
        if (rd_en) begin
            if (addr == OFS_DATA && !divsel) begin
                st_d.lsta[LS_READY] = 1'b0;
                st_d.lsta[LS_BREAK] = 1'b0;
            end
            if (addr == OFS_ID && id_cur == ID_TX) begin
                st_d.tx_pend = 1'b0;
            end
        end

        // receive side
        if (rx_break) begin
            st_d.rbuf           = '0;
            st_d.lsta[LS_READY] = 1'b1;
            st_d.lsta[LS_BREAK] = 1'b1;
        end else if (rx_valid && !st_q.lsta[LS_READY]) begin
            st_d.rbuf           = rx_data;
            st_d.lsta[LS_READY] = 1'b1;
        end

        st_d.irq = (id_nxt != ID_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lsta <= LS_RESET;
            st_q.msta <= MSTA_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid   = st_q.txv;
    assign tx_data    = st_q.txb;
    assign irq        = st_q.irq;
    assign divisor    = st_q.div;
    assign line_ctrl  = st_q.lctl;
    assign modem_ctrl = st_q.mctl;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       addr,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             rd_en,
    input logic [7:0]       rd_data,
    input logic             rx_valid,
    input logic             rx_break,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             irq,
    input logic [DIV_W-1:0] divisor,
    input logic [7:0]       line_ctrl,
    input logic [7:0]       modem_ctrl
);
    // R4
    irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd2) |-> (irq == (rd_data != 8'h01)));

    // R5
    id_read_clears_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2 && rd_data == 8'h02 && !wr_en && !rx_valid && !rx_break)
        |=> !irq);

    // R7
    data_write_sends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !line_ctrl[7]) |=> (tx_valid && tx_data == $past(wr_data)));

    // R2
    div_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && line_ctrl[7])
        |=> (divisor[7:0] == $past(wr_data) && !tx_valid));

    // R3
    mctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4) |=> (modem_ctrl == {3'b000, $past(wr_data[4:0])}));

    // R7
    tx_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(wr_en && addr == 3'd0 && !line_ctrl[7]));
endmodule

bind uart_regbank uart_regbank_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rx_valid   (rx_valid),
    .rx_break   (rx_break),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .irq        (irq),
    .divisor    (divisor),
    .line_ctrl  (line_ctrl),
    .modem_ctrl (modem_ctrl)
);

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 34;

    // entry: {req[3:0], op, addr[2:0], data[7:0]}; op 1 = read and compare
    localparam logic [15:0] VEC [NVEC] = '{
        16'h1D60, 16'h1A01, 16'h1EB0,                 // R1 reset values
        16'h37A5, 16'h3FA5,                           // R3 scratch
        16'h31FF, 16'h390F, 16'h4A02, 16'h5A01,       // R3 mask, R4, R5
        16'h6100, 16'h6102, 16'h6A02, 16'h5A01,       // R6 then R5
        16'h6100,
        16'h34FF, 16'h3C1F, 16'hBEF0,                 // R3 mctl mask, R11
        16'hB415, 16'hBE60, 16'hB41A, 16'hBE90,       // R11 mapping
        16'hB400, 16'hBEB0,
        16'h3255, 16'h3A01, 16'h3500, 16'h3D60,       // R3 ignored offsets
        16'h3600, 16'h3EB0,
        16'h2380, 16'h2034, 16'h2112, 16'h2834, 16'h2912 // R2 divisor
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] addr = '0;
    logic       wr_en = 0, rd_en = 0, rx_valid = 0, rx_break = 0;
    logic [7:0] wr_data = '0, rx_data = '0;
    logic [7:0] rd_data, tx_data, line_ctrl, modem_ctrl;
    logic       tx_valid, irq;
    logic [15:0] divisor;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq),
        .divisor(divisor), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1;
        check(req, {8'h00, rd_data}, {8'h00, exp});
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic push(input logic [7:0] d, input logic brk);
        @(negedge clk);
        rx_data = d; rx_valid = !brk; rx_break = brk;
        @(negedge clk);
        rx_valid = 0; rx_break = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
        check("R1 divisor", divisor, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][15:12], i);
            if (VEC[i][11]) rd(tag, VEC[i][10:8], VEC[i][7:0]);
            else            wr(VEC[i][10:8], VEC[i][7:0]);
        end

        // R2: DLAB reads, no transmit pulse, enable byte untouched
        rd("R2 lctl", 3'd3, 8'h80);
        check("R2 divisor", divisor, 16'h1234);
        wr(3'd0, 8'h34);
        check("R2 no tx", {15'd0, tx_valid}, 16'd0);
        wr(3'd3, 8'h03);
        rd("R2 ien kept", 3'd1, 8'h00);

        // R7: data write
        wr(3'd1, 8'h02);
        rd("R6 id", 3'd2, 8'h02);
        rd("R5 id", 3'd2, 8'h01);
        check("R5 irq", {15'd0, irq}, 16'd0);
        wr(3'd0, 8'h5A);
        check("R7 tx_valid", {15'd0, tx_valid}, 16'd1);
        check("R7 tx_data", {8'h00, tx_data}, 16'h005A);
        check("R7 irq", {15'd0, irq}, 16'd1);
        @(negedge clk);
        check("R7 pulse", {15'd0, tx_valid}, 16'd0);
        rd("R7 lsta", 3'd5, 8'h60);
        rd("R7 id", 3'd2, 8'h02);
        check("R5 irq drop", {15'd0, irq}, 16'd0);

        // R9, R8
        wr(3'd1, 8'h01);
        push(8'h3C, 1'b0);
        check("R4 irq rx", {15'd0, irq}, 16'd1);
        rd("R4 id rx", 3'd2, 8'h04);
        rd("R9 lsta", 3'd5, 8'h61);
        push(8'h99, 1'b0);
        rd("R9 kept", 3'd0, 8'h3C);
        rd("R8 lsta", 3'd5, 8'h60);
        check("R8 irq", {15'd0, irq}, 16'd0);

        // R4 priority
        wr(3'd1, 8'h03);
        push(8'h77, 1'b0);
        rd("R4 prio", 3'd2, 8'h04);
        rd("R8 data", 3'd0, 8'h77);
        rd("R4 tx next", 3'd2, 8'h02);
        rd("R5 cleared", 3'd2, 8'h01);
        check("R4 irq", {15'd0, irq}, 16'd0);

        // R10 break
        wr(3'd1, 8'h00);
        push(8'hEE, 1'b1);
        rd("R10 lsta", 3'd5, 8'h71);
        rd("R10 data", 3'd0, 8'h00);
        rd("R10 cleared", 3'd5, 8'h60);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule